// File: doc/BRIEF.md
# Pin-Change Interrupt Generator

This block watches a group of general-purpose port pins and raises a shared, active-low interrupt whenever any pin level differs from a stored reference copy of the pins. The pins arrive asynchronously. A chain of flops brings them into the clock domain before they are compared with the reference. The interrupt follows the comparison. It drops by itself when the pins go back to the reference values. It is also cleared, and the reference reloaded from the live pins, when the bus side of the device reads or writes the port.

The output does not drive a level. It is a pull-down enable for an open-drain pad. When it is high the pad sinks the shared interrupt line, so several devices can be wired together on one line. Read and write strobes come from bus logic in the same clock domain. A read clears on the first cycle its strobe is high. A write keeps the interrupt off for as long as its strobe is high, and takes a final reference copy when the strobe falls.

Top module: `pin_change_irq`

## Requirements
- R1: While reset is asserted, and afterwards while the pins hold still, `irq_oe` is 0. The pin levels present when reset is released become the reference.
- R2: A low-to-high change on any single pin sets `irq_oe` to 1 at the third rising clock edge after the change, and not earlier.
- R3: A high-to-low change on any single pin sets `irq_oe` to 1 at the third rising clock edge after the change, and not earlier.
- R4: When several pins change together, `irq_oe` is set. It stays at 1 for as long as the pins differ from the reference and no access occurs.
- R5: When the pins return to the reference values, `irq_oe` returns to 0 at the third rising clock edge after the return.
- R6: At the first clock edge where `rd_pulse` is high after being low, `irq_oe` goes to 0 and the reference is reloaded from the synchronized pins. The interrupt stays off while the pins stay at those levels.
- R7: Only the rising edge of `rd_pulse` clears. A pin change while `rd_pulse` is held high, or a falling edge of `rd_pulse`, does not stop `irq_oe` from being set.
- R8: `irq_oe` is 0 from the first clock edge where `wr_pulse` is high, through the edge where it is first seen low. The reference is reloaded on every one of those edges, so pin changes that settle during the write raise no interrupt.
- R9: After any clear, a change relative to the new reference is detected again. This includes a return to the levels that were the reference before the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | W | Asynchronous pin levels from the port pads |
| rd_pulse | input | 1 | Port read strobe from the bus side, synchronous to clk |
| wr_pulse | input | 1 | Port write strobe from the bus side, synchronous to clk |
| irq_oe | output | 1 | Pull-down enable for the open-drain interrupt pad, 1 means line low |

## Verification
A pin change passes two synchronizer flops and then the interrupt register, so `irq_oe` is due at the third rising edge after the change. The bench samples at the falling edge after the second edge to confirm it is still low, and again after the third edge to confirm it is high. A return to the reference follows the same three-edge path. A read or write strobe acts on the interrupt register directly, so its effect is checked at the falling edge right after the first edge that sees the strobe. All stimulus is applied at falling edges, which keeps each expected change on a whole-edge count.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  // Edge test on a strobe against its registered previous value.
  function automatic logic edge_hit(input edge_kind_e kind, input logic cur, input logic prev);
    if (kind == EDGE_RISE) return cur & ~prev;
    else                   return ~cur & prev;
  endfunction

  // Count of pins that differ between two samples (generic width up to 32).
  function automatic int unsigned diff_count(input logic [31:0] a, input logic [31:0] b);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(a[i] ^ b[i]);
    return n;
  endfunction

endpackage

// File: rtl/irqgen_sync.sv
module irqgen_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irqgen_edge.sv
module irqgen_edge
  import pin_change_irq_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe;
  end

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign hit = edge_hit(EDGE_RISE, strobe, prev_q);
    end else begin : g_fall
      assign hit = edge_hit(EDGE_FALL, strobe, prev_q);
    end
  endgenerate
endmodule

// File: rtl/irqgen_settle.sv
module irqgen_settle #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  localparam int LAST = STAGES + 1;
  localparam int CW   = $clog2(LAST + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (cnt_q != CW'(LAST))   cnt_q <= cnt_q + CW'(1);
  end

  // Busy until the synchronizer output carries real pin levels and one
  // reference load has taken them.
  assign busy = (cnt_q <= CW'(STAGES));
endmodule

// File: rtl/irqgen_core.sv
module irqgen_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_s,
  input  logic         reload,
  output logic [W-1:0] snap_q,
  output logic         mismatch,
  output logic         irq_q
);
  function automatic logic any_diff(input logic [W-1:0] a, input logic [W-1:0] b);
    return |(a ^ b);
  endfunction

  assign mismatch = any_diff(pins_s, snap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      irq_q  <= 1'b0;
    end else if (reload) begin
      snap_q <= pins_s;
      irq_q  <= 1'b0;
    end else begin
      irq_q  <= mismatch;
    end
  end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pin_change_irq_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_raw,
  input  logic         rd_pulse,
  input  logic         wr_pulse,
  output logic         irq_oe
);
  // Named internal events, visible to the bound checker.
  logic [W-1:0] pins_s;
  logic [W-1:0] snap_q;
  logic         settle_busy;
  logic         rd_rise;
  logic         wr_fall;
  logic         reload;
  logic         mismatch;
  logic         irq_q;

  irqgen_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_raw), .q_sync(pins_s)
  );

  irqgen_settle #(.STAGES(SYNC_STAGES)) u_settle (
    .clk(clk), .rst_n(rst_n), .busy(settle_busy)
  );

  irqgen_edge #(.KIND(EDGE_RISE)) u_rd_edge (
    .clk(clk), .rst_n(rst_n), .strobe(rd_pulse), .hit(rd_rise)
  );

  irqgen_edge #(.KIND(EDGE_FALL)) u_wr_edge (
    .clk(clk), .rst_n(rst_n), .strobe(wr_pulse), .hit(wr_fall)
  );

  // Clear-and-reload: settling after reset, read start (R6), whole write
  // window plus its closing edge (R8).
  assign reload = settle_busy | rd_rise | wr_pulse | wr_fall;

  irqgen_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .pins_s(pins_s), .reload(reload),
    .snap_q(snap_q), .mismatch(mismatch), .irq_q(irq_q)
  );

  assign irq_oe = irq_q;
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_pulse,
  input logic         wr_pulse,
  input logic         irq_oe,
  input logic [W-1:0] pins_s,
  input logic [W-1:0] snap_q,
  input logic         reload,
  input logic         settle_busy
);
  assert_settle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |=> !irq_oe);

  assert_irq_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> ($past(pins_s) != $past(snap_q)) && !$past(reload));

  assert_diff_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pins_s != snap_q) && !reload) |=> irq_oe);

  assert_match_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_s == snap_q) |=> !irq_oe);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && !$past(rd_pulse)) |=> !irq_oe);

  assert_write_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !irq_oe);

  assert_write_end_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pulse && $past(wr_pulse)) |=> !irq_oe);

  assert_ref_moves_on_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_q != $past(snap_q)) |-> $past(reload));
endmodule

bind pin_change_irq pin_change_irq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
  .irq_oe(irq_oe), .pins_s(pins_s), .snap_q(snap_q), .reload(reload),
  .settle_busy(settle_busy)
);

// File: tb/tb_pin_change_irq.sv
module tb_pin_change_irq;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] pins;
  logic         rd, wr;
  logic         irq_oe;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pin_change_irq #(.W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pins),
    .rd_pulse(rd), .wr_pulse(wr), .irq_oe(irq_oe)
  );

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  // R1: quiet through reset and after release
  task automatic t_reset();
    rst_n = 1'b0; pins = 8'hA5; rd = 1'b0; wr = 1'b0;
    tick(3);
    chk(irq_oe, 1'b0, "R1", "during reset");
    rst_n = 1'b1;
    tick(6);
    chk(irq_oe, 1'b0, "R1", "after release, static pins");
  endtask

  // R2 / R3 / R5: each pin toggled alone, then restored
  task automatic t_each_pin();
    for (int i = 0; i < W; i++) begin
      string tag;
      tag = pins[i] ? "R3" : "R2";
      pins[i] = ~pins[i];
      tick(2);
      chk(irq_oe, 1'b0, tag, $sformatf("pin %0d not yet at edge 2", i));
      tick(1);
      chk(irq_oe, 1'b1, tag, $sformatf("pin %0d asserted at edge 3", i));
      pins[i] = ~pins[i];
      tick(2);
      chk(irq_oe, 1'b1, "R5", $sformatf("pin %0d still set at edge 2 of return", i));
      tick(1);
      chk(irq_oe, 1'b0, "R5", $sformatf("pin %0d cleared at edge 3 of return", i));
    end
  endtask

  // R4: several pins together, held
  task automatic t_multi();
    pins = pins ^ 8'h3C;
    tick(3);
    chk(irq_oe, 1'b1, "R4", "group change asserts");
    tick(5);
    chk(irq_oe, 1'b1, "R4", "stays set while pins differ");
  endtask

  // R6 / R9: read clears and reloads reference
  task automatic t_read();
    rd = 1'b1;
    tick(1);
    chk(irq_oe, 1'b0, "R6", "cleared at first edge of read");
    rd = 1'b0;
    tick(4);
    chk(irq_oe, 1'b0, "R6", "stays clear at new reference");
    pins = pins ^ 8'h3C;  // back to pre-read levels
    tick(3);
    chk(irq_oe, 1'b1, "R9", "return to old levels detected after read");
    rd = 1'b1; tick(1); rd = 1'b0; tick(3);
    chk(irq_oe, 1'b0, "R6", "second read clears");
  endtask

  // R7: held read only clears once
  task automatic t_read_held();
    rd = 1'b1;
    tick(1);
    pins[0] = ~pins[0];
    tick(3);
    chk(irq_oe, 1'b1, "R7", "change during held read asserts");
    rd = 1'b0;
    tick(1);
    chk(irq_oe, 1'b1, "R7", "read fall does not clear");
    rd = 1'b1; tick(1); rd = 1'b0;
    chk(irq_oe, 1'b0, "R7", "new read rise clears");
    tick(3);
  endtask

  // R8 / R9: write window
  task automatic t_write();
    pins = pins ^ 8'h81;
    tick(3);
    chk(irq_oe, 1'b1, "R8", "setup change asserts");
    wr = 1'b1;
    tick(1);
    chk(irq_oe, 1'b0, "R8", "cleared at first edge of write");
    pins = pins ^ 8'h0F;
    tick(5);
    chk(irq_oe, 1'b0, "R8", "held off during write despite change");
    wr = 1'b0;
    tick(1);
    chk(irq_oe, 1'b0, "R8", "clear at write end edge");
    tick(4);
    chk(irq_oe, 1'b0, "R8", "changes inside write absorbed");
    pins = pins ^ 8'h0F;
    tick(3);
    chk(irq_oe, 1'b1, "R9", "change after write detected");
  endtask

  initial begin
    t_reset();
    t_each_pin();
    t_multi();
    t_read();
    t_read_held();
    t_write();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule